// File: doc/BRIEF.md
# Page-buffered EEPROM write controller

This block is a synchronous model of the write side of a byte-wide nonvolatile memory. It samples active-low chip-enable, output-enable and write-enable strobes together with an address bus and a data bus. A write pulse is a stretch of cycles in which chip-enable and write-enable are both low. Each qualified pulse loads one byte into a page buffer, and the buffer keeps a valid flag for every byte it holds.

Loading goes on while each new byte arrives within a byte-load window of the one before it. When the window expires, a self-timed programming period starts. At the end of that period only the bytes that were loaded are written into a behavioural storage array. A busy flag covers the whole span from the first byte to the end of programming. The address and data of the last accepted byte are held on outputs, and a separate read index shows the stored contents.

A supply-good input gates all writing, and a power-on delay applies after it rises. The window, the programming time and the power-on delay are counted in clock cycles.

Top module: `eeprom_page_writer`

## Requirements
- R1: A write pulse starts in the cycle where `ce_n` and `we_n` are first seen both low, and it ends in the first later cycle where either of them is seen high. The pulse is qualified only if `oe_n` is high when it starts and stays high in every cycle it is active. An unqualified pulse changes nothing.
- R2: A pulse takes the address present in its first active cycle and the data present in its last active cycle. Address changes later in the pulse have no effect.
- R3: The byte is accepted at the clock edge that first sees the pulse ended. After reset `busy`, `last_addr` and `last_data` are 0. A byte accepted while idle raises `busy` and sets the load page to address bits [12:6]. Every accepted byte updates `last_addr` and `last_data` at the edge that accepts it.
- R4: During loading, a byte is accepted if its acceptance edge is at most `LOAD_WIN` cycles after the previous acceptance. If `LOAD_WIN` cycles pass with no accepted byte, programming starts.
- R5: During loading, a byte whose address bits [12:6] differ from the load page is ignored. It leaves the outputs unchanged, is never stored, and does not restart the window.
- R6: Bytes of a page may arrive in any order, using address bits [5:0] as the byte offset, and up to all 64 of them may be loaded. A byte written twice keeps the later value.
- R7: After reset every stored byte reads 0xFF. Programming writes only the loaded offsets, and all other bytes keep their value.
- R8: Programming lasts `PROG_CYC` cycles. At its last edge the array is updated and `busy` falls. Pulses that end while programming is in progress are ignored.
- R9: No byte is accepted while `supply_ok` is low. After `supply_ok` rises, a byte is accepted only once `supply_ok` has been high for `POR_CYC` clock edges in a row.
- R10: `rd_data` shows, combinationally, the stored byte at index `rd_addr`. The storage holds 2^`STORE_PAGE_W` pages. A written address maps to index {page bits [STORE_PAGE_W+5:6], offset [5:0]}, so higher page bits alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-good indication, writes blocked when low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low, must be high to write |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Write address, page in [12:6], offset in [5:0] |
| wdata | input | DATA_W | Write data |
| rd_addr | input | STORE_PAGE_W+6 | Storage index to observe |
| rd_data | output | DATA_W | Stored byte at `rd_addr` |
| busy | output | 1 | High from first accepted byte to end of programming |
| last_addr | output | ADDR_W | Address of last accepted byte |
| last_data | output | DATA_W | Data of last accepted byte |

## Verification
The assertions assume that all inputs change away from the rising clock edge and that reset is asserted before the first edge that counts. The timing counters of R4 and R8 must therefore start from a known zero. They also assume `PROG_CYC`, `LOAD_WIN` and `POR_CYC` are at least 2, 2 and 1. The stimulus drives every strobe, address and data change on the falling edge and holds reset across the first edges. It uses short cycle counts for all three delays and sweeps the gap between loaded bytes across the window boundary.

// File: rtl/epw_pkg.sv
package epw_pkg;

    // controller phase
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } wr_state_e;

endpackage

// File: rtl/epw_strobe.sv
module epw_strobe #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              pulse_end,
    output logic              pulse_ok,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data
);

    typedef struct packed {
        logic              act;
        logic              ok;
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] d;
    } stb_t;

    stb_t stb_q, stb_d;
    logic act_now;

    assign act_now = !ce_n && !we_n;

    always_comb begin
        stb_d     = stb_q;
        stb_d.act = act_now;
        if (act_now && !stb_q.act) begin
            stb_d.a  = addr;
            stb_d.ok = oe_n;
        end else if (act_now && !oe_n) begin
            stb_d.ok = 1'b0;
        end
        if (act_now) begin
            stb_d.d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stb_q <= '0;
        else        stb_q <= stb_d;
    end

    assign pulse_end = stb_q.act && !act_now;
    assign pulse_ok  = stb_q.ok;
    assign cap_addr  = stb_q.a;
    assign cap_data  = stb_q.d;

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (act_now && stb_q.act) |=> $stable(cap_addr)); // R2

    AST_OE_LOW_DISQUALIFIES: assert property (@(posedge clk) disable iff (!rst_n)
        (act_now && !oe_n) |=> !pulse_ok); // R1

endmodule

// File: rtl/epw_por.sv
module epw_por #(
    parameter int POR_CYC = 125000,
    localparam int CW = $clog2(POR_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    output logic por_done
);

    localparam logic [CW-1:0] DONE = CW'(POR_CYC);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (!supply_ok)         cnt_d = '0;
        else if (cnt_q != DONE) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign por_done = (cnt_q == DONE);

    AST_POR_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !por_done); // R9

endmodule

// File: rtl/epw_page_buf.sv
module epw_page_buf #(
    parameter int PAGE_BYTES = 64,
    parameter int DATA_W     = 8,
    localparam int OFF_W = $clog2(PAGE_BYTES)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                clear,
    input  logic                                wr_en,
    input  logic [OFF_W-1:0]                    wr_idx,
    input  logic [DATA_W-1:0]                   wr_data,
    output logic [PAGE_BYTES-1:0][DATA_W-1:0]   buf_data,
    output logic [PAGE_BYTES-1:0]               buf_valid
);

    typedef struct packed {
        logic [PAGE_BYTES-1:0][DATA_W-1:0] data;
        logic [PAGE_BYTES-1:0]             valid;
    } pbuf_t;

    pbuf_t pb_q, pb_d;

    always_comb begin
        pb_d = pb_q;
        if (clear) pb_d.valid = '0;
        if (wr_en) begin
            pb_d.valid[wr_idx] = 1'b1;
            pb_d.data[wr_idx]  = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pb_q <= '0;
        else        pb_q <= pb_d;
    end

    assign buf_data  = pb_q.data;
    assign buf_valid = pb_q.valid;

    AST_FIRST_BYTE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && wr_en) |=> ($countones(buf_valid) == 1)); // R3

    AST_VALID_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ($countones(buf_valid) >= $countones($past(buf_valid)))); // R6

endmodule

// File: rtl/epw_array.sv
module epw_array #(
    parameter int PAGE_BYTES   = 64,
    parameter int DATA_W       = 8,
    parameter int STORE_PAGE_W = 5,
    localparam int OFF_W = $clog2(PAGE_BYTES),
    localparam int IDX_W = STORE_PAGE_W + OFF_W,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              commit_en,
    input  logic [STORE_PAGE_W-1:0]           commit_page,
    input  logic [PAGE_BYTES-1:0][DATA_W-1:0] buf_data,
    input  logic [PAGE_BYTES-1:0]             buf_valid,
    input  logic [IDX_W-1:0]                  rd_idx,
    output logic [DATA_W-1:0]                 rd_data
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (commit_en) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (buf_valid[i]) mem_q[{commit_page, OFF_W'(i)}] <= buf_data[i];
            end
        end
    end

    assign rd_data = mem_q[rd_idx];

    AST_ARRAY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_en |=> (!$stable(rd_idx) || $stable(rd_data))); // R7

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import epw_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int DATA_W       = 8,
    parameter int PAGE_BYTES   = 64,
    parameter int STORE_PAGE_W = 5,
    parameter int LOAD_WIN     = 3750,
    parameter int PROG_CYC     = 250000,
    parameter int POR_CYC      = 125000,
    localparam int OFF_W  = $clog2(PAGE_BYTES),
    localparam int PAGE_W = ADDR_W - OFF_W,
    localparam int IDX_W  = STORE_PAGE_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic [ADDR_W-1:0] last_addr,
    output logic [DATA_W-1:0] last_data
);

    localparam int GAP_W  = $clog2(LOAD_WIN + 1);
    localparam int PROG_W = $clog2(PROG_CYC + 1);
    localparam logic [GAP_W-1:0]  GAP_LAST  = GAP_W'(LOAD_WIN - 1);
    localparam logic [PROG_W-1:0] PROG_LAST = PROG_W'(PROG_CYC - 1);

    typedef struct packed {
        wr_state_e         st;
        logic [PAGE_W-1:0] page;
        logic [GAP_W-1:0]  gap;
        logic [PROG_W-1:0] prog;
        logic [ADDR_W-1:0] l_addr;
        logic [DATA_W-1:0] l_data;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic              pulse_end, pulse_ok, por_done, wr_ok;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;
    logic [PAGE_W-1:0] cap_page;
    logic [OFF_W-1:0]  cap_off;
    logic              accept, buf_clear, commit_en;
    logic [PAGE_BYTES-1:0][DATA_W-1:0] buf_data;
    logic [PAGE_BYTES-1:0]             buf_valid;

    epw_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .pulse_end(pulse_end), .pulse_ok(pulse_ok),
        .cap_addr(cap_addr), .cap_data(cap_data)
    );

    epw_por #(.POR_CYC(POR_CYC)) u_por (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .por_done(por_done)
    );

    assign wr_ok    = supply_ok && por_done;
    assign cap_page = cap_addr[ADDR_W-1:OFF_W];
    assign cap_off  = cap_addr[OFF_W-1:0];

    always_comb begin
        accept = pulse_end && pulse_ok && wr_ok && (ctl_q.st != ST_PROG) &&
                 ((ctl_q.st == ST_IDLE) || (cap_page == ctl_q.page));
        buf_clear = accept && (ctl_q.st == ST_IDLE);
        commit_en = (ctl_q.st == ST_PROG) && (ctl_q.prog == PROG_LAST);
    end

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.st)
            ST_IDLE: begin
                if (accept) begin
                    ctl_d.st   = ST_LOAD;
                    ctl_d.page = cap_page;
                    ctl_d.gap  = '0;
                end
            end
            ST_LOAD: begin
                if (accept) begin
                    ctl_d.gap = '0;
                end else if (ctl_q.gap == GAP_LAST) begin
                    ctl_d.st   = ST_PROG;
                    ctl_d.prog = '0;
                end else begin
                    ctl_d.gap = ctl_q.gap + 1'b1;
                end
            end
            ST_PROG: begin
                if (ctl_q.prog == PROG_LAST) ctl_d.st   = ST_IDLE;
                else                         ctl_d.prog = ctl_q.prog + 1'b1;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
        if (accept) begin
            ctl_d.l_addr = cap_addr;
            ctl_d.l_data = cap_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    epw_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_pbuf (
        .clk(clk), .rst_n(rst_n), .clear(buf_clear), .wr_en(accept),
        .wr_idx(cap_off), .wr_data(cap_data),
        .buf_data(buf_data), .buf_valid(buf_valid)
    );

    epw_array #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W), .STORE_PAGE_W(STORE_PAGE_W)) u_array (
        .clk(clk), .rst_n(rst_n), .commit_en(commit_en),
        .commit_page(ctl_q.page[STORE_PAGE_W-1:0]),
        .buf_data(buf_data), .buf_valid(buf_valid),
        .rd_idx(rd_addr), .rd_data(rd_data)
    );

    assign busy      = (ctl_q.st != ST_IDLE);
    assign last_addr = ctl_q.l_addr;
    assign last_data = ctl_q.l_data;

    AST_IDLE_STAYS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_q.st == ST_IDLE) && !accept) |=> !busy); // R3

    AST_WINDOW_EXPIRES: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_q.st == ST_LOAD) && (ctl_q.gap == GAP_LAST) && !accept) |=> (ctl_q.st == ST_PROG)); // R4

    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st != ST_IDLE) |=> ((ctl_q.st == ST_IDLE) || $stable(ctl_q.page))); // R5

    AST_PROG_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_PROG) |=> ($stable(last_addr) && $stable(last_data))); // R8

    AST_PROG_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_PROG) |-> (ctl_q.prog <= PROG_LAST)); // R8

    AST_SUPPLY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> ($stable(last_addr) && $stable(last_data))); // R9

endmodule

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LOAD_WIN   = 20;
    localparam int PROG_CYC   = 40;
    localparam int POR_CYC    = 16;
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        supply_ok = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [12:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [10:0] rd_addr = '0;
    logic [7:0]  rd_data;
    logic        busy;
    logic [12:0] last_addr;
    logic [7:0]  last_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_page_writer #(
        .ADDR_W(13), .DATA_W(8), .PAGE_BYTES(64), .STORE_PAGE_W(5),
        .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC), .POR_CYC(POR_CYC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr), .wdata(wdata),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .last_addr(last_addr), .last_data(last_data)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    done = 0;
    string cur_req = "R3";

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    logic [7:0]  m_mem [2048];
    logic [7:0]  m_buf [64];
    bit          m_vld [64];
    int          m_state, m_gap, m_pc, m_por;
    logic [6:0]  m_page;
    logic [12:0] m_ahold, m_last_addr;
    logic [7:0]  m_dhold, m_last_data;
    bit          m_act, m_pv, s_act, s_wok, s_take;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 8'hFF;
            foreach (m_vld[i]) m_vld[i] = 0;
            m_state = 0; m_gap = 0; m_pc = 0; m_por = 0;
            m_page = '0; m_ahold = '0; m_dhold = '0;
            m_last_addr = '0; m_last_data = '0; m_act = 0; m_pv = 0;
        end else begin
            s_act  = !ce_n && !we_n;
            s_wok  = supply_ok && (m_por == POR_CYC);
            s_take = m_act && !s_act && m_pv && s_wok && (m_state != 2) &&
                     (m_state == 0 || m_ahold[12:6] == m_page);
            case (m_state)
                0: if (s_take) begin
                    m_state = 1; m_page = m_ahold[12:6]; m_gap = 0;
                    foreach (m_vld[i]) m_vld[i] = 0;
                end
                1: if (s_take) m_gap = 0;
                   else if (m_gap == LOAD_WIN - 1) begin m_state = 2; m_pc = 0; end
                   else m_gap++;
                default: if (m_pc == PROG_CYC - 1) begin
                    for (int i = 0; i < 64; i++)
                        if (m_vld[i]) m_mem[{m_page[4:0], 6'(i)}] = m_buf[i];
                    m_state = 0;
                end else m_pc++;
            endcase
            if (s_take) begin
                m_vld[m_ahold[5:0]] = 1;
                m_buf[m_ahold[5:0]] = m_dhold;
                m_last_addr = m_ahold;
                m_last_data = m_dhold;
            end
            if (s_act && !m_act) begin m_ahold = addr; m_pv = oe_n; end
            else if (s_act && !oe_n) m_pv = 0;
            if (s_act) m_dhold = wdata;
            m_act = s_act;
            if (!supply_ok) m_por = 0;
            else if (m_por < POR_CYC) m_por++;
        end
    end

    // per-clock comparison, away from the edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk(cur_req, busy, (m_state != 0));
            chk(cur_req, last_addr, m_last_addr);
            chk(cur_req, last_data, m_last_data);
            chk(cur_req, rd_data, m_mem[rd_addr]);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=%0d exp<%0d", cyc, WD_LIMIT);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic pulse(input logic [12:0] a, input logic [7:0] d0, input logic [7:0] dl,
                         input bit oe_glitch, input bit ce_ends, input bit scramble);
        @(negedge clk);
        addr = a; wdata = d0; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        wdata = dl;
        if (scramble) addr = ~a;
        if (oe_glitch) oe_n = 1'b0;
        @(negedge clk);
        oe_n = 1'b1;
        if (ce_ends) ce_n = 1'b1; else we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; addr = '0; wdata = '0;
    endtask

    task automatic wr(input logic [12:0] a, input logic [7:0] d);
        pulse(a, d, d, 0, 0, 0);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic peek(input string req, input logic [10:0] idx, input logic [7:0] exp);
        @(negedge clk);
        rd_addr = idx;
        #1;
        chk(req, rd_data, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R3", busy, 0);
        chk("R3", last_addr, 0);
        chk("R3", last_data, 0);
        peek("R7", 11'h005, 8'hFF);

        // R9: supply low, then inside power-on delay
        cur_req = "R9";
        wr(13'h0145, 8'h11);
        #1; chk("R9", busy, 0); chk("R9", last_addr, 0);
        @(negedge clk); supply_ok = 1'b1;
        wr(13'h0146, 8'h12);
        #1; chk("R9", busy, 0); chk("R9", last_addr, 0);
        repeat (POR_CYC + 4) @(negedge clk);

        // R3 / R6: out of order with a rewrite
        cur_req = "R6";
        wr(13'h0143, 8'h33);
        #1; chk("R3", busy, 1); chk("R3", last_addr, 13'h0143);
        wr(13'h0141, 8'h11);
        wr(13'h014A, 8'hAA);
        wr(13'h0143, 8'h3C);
        #1; chk("R6", last_data, 8'h3C);
        cur_req = "R8";
        wait_idle();
        peek("R6", 11'h143, 8'h3C);
        peek("R7", 11'h142, 8'hFF);
        peek("R7", 11'h141, 8'h11);
        peek("R10", 11'h14A, 8'hAA);

        // R5: foreign page during load
        cur_req = "R5";
        wr(13'h0200, 8'h01);
        wr(13'h0240, 8'h77);
        #1; chk("R5", last_addr, 13'h0200); chk("R5", last_data, 8'h01);
        wait_idle();
        peek("R5", 11'h240, 8'hFF);
        peek("R5", 11'h200, 8'h01);

        // R1: oe glitch disqualifies; chip-enable may end the pulse
        cur_req = "R1";
        pulse(13'h0301, 8'hE1, 8'hE1, 1, 0, 0);
        #1; chk("R1", busy, 0); chk("R1", last_addr, 13'h0200);
        pulse(13'h0302, 8'h5A, 8'h5A, 0, 1, 0);
        #1; chk("R1", busy, 1); chk("R1", last_addr, 13'h0302);
        wait_idle();
        peek("R1", 11'h301, 8'hFF);

        // R2: address from first cycle, data from last
        cur_req = "R2";
        pulse(13'h0080, 8'h12, 8'h34, 0, 0, 1);
        #1; chk("R2", last_addr, 13'h0080); chk("R2", last_data, 8'h34);
        wait_idle();
        peek("R2", 11'h080, 8'h34);

        // R8: pulses during programming ignored
        cur_req = "R8";
        wr(13'h00C0, 8'h66);
        repeat (LOAD_WIN + 3) @(negedge clk);
        wr(13'h00C1, 8'h99);
        #1; chk("R8", busy, 1); chk("R8", last_addr, 13'h00C0);
        wait_idle();
        peek("R8", 11'h0C1, 8'hFF);
        peek("R8", 11'h0C0, 8'h66);

        // R4: sweep the gap across the window edge
        cur_req = "R4";
        for (int g = LOAD_WIN - 6; g <= LOAD_WIN; g++) begin
            wr(13'h0100, 8'(g));
            repeat (g) @(negedge clk);
            wr(13'h0101, 8'(g + 100));
            wait_idle();
            peek("R4", 11'h101, m_mem[11'h101]);
        end

        // R10: higher page bits alias onto stored pages
        cur_req = "R10";
        wr(13'h0942, 8'hC2);
        wait_idle();
        peek("R10", 11'h142, 8'hC2);

        // R6: complete page, descending order
        cur_req = "R6";
        for (int i = 63; i >= 0; i--) wr({7'd7, 6'(i)}, 8'(i) ^ 8'h5A);
        wait_idle();
        for (int i = 0; i < 64; i++) peek("R6", {5'd7, 6'(i)}, 8'(i) ^ 8'h5A);

        done = 1;
        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule